// File: doc/BRIEF.md
# D-PHY Lane High-Speed Burst Sequencer

This block is the transmit-side control sequencer for one D-PHY clock lane and a parameterised number of data lanes (four by default). It runs on the lane byte clock. A link layer holds a burst request high to open a high-speed burst and drops it to close the burst. The sequencer walks the clock lane into high-speed mode first, then the data lanes. At the end of a burst it walks them back in the opposite order, with every window length taken from packed timing inputs in byte-clock counts.

Each lane has its own high-speed enable, low-power enable and a pair of low-power line levels. Each enable can be taken from the sequencer or from a per-lane override. Lane power-down follows the configured lane count. A 4-bit status nibble per lane exposes the stop and high-speed-active state. Soft resets are provided for the whole PHY and for each lane, and a force-stop control is provided for the data lanes.

Top module: `dphy_burst_seq`

## Requirements
- R1: The clock lane leaves stop (LP-11) only by driving LP-01 and then LP-00, each for LPX cycles, before its high-speed enable rises. A data lane likewise enters only through LP-01 then LP-00, each for LPX cycles. LPX is `lpx_i`.
- R2: The data-lane LP-01 step starts exactly prepare+zero+clock-pre cycles after the clock lane's high-speed enable rises. Clock prepare is `clk_tim_i[31:24]`, clock zero is `clk_tim_i[23:16]` and clock-pre is `clk_pre_i`. No data lane leaves stop while the clock lane is not in high-speed mode.
- R3: A data lane stays in high-speed mode for hs-prepare + hs-zero + B + hs-trail cycles. The fields are `hs_tim_i[31:24]`, `[23:16]` and `[15:8]`, and B is the number of cycles that `hs_ready_o` is high. `hs_ready_o` falls on the first clock edge that samples `burst_req_i` low. All active data lanes carry identical line states.
- R4: After the data lanes return to LP-11, the clock lane stays in high-speed mode for clock-post + clock-trail cycles (`clk_tim_i[15:8]`, `[7:0]`) and then returns to LP-11. With the request held high, the clock lane then stays in LP-11 for hs-exit + 1 cycles (`hs_tim_i[7:0]`) before the next burst starts.
- R5: A timing field of zero lasts one cycle.
- R6: `pd_o[k]` for data lane k is 1 when `phy_off_i` is high or k >= `lane_cnt_i`. `pd_o[NUM_LANES]` (the clock lane) equals `phy_off_i`, and `phy_off_i` also holds the sequencer idle.
- R7: A powered-down lane without override drives high-speed enable, low-power enable and both line levels at 0.
- R8: For every lane, when `ovr_hs_sel_i[k]` is 1, `tx_hs_en_o[k]` equals `ovr_hs_val_i[k]`, and when it is 0 the enable comes from the sequencer. `ovr_lp_sel_i` and `ovr_lp_val_i` work the same way for `tx_lp_en_o`.
- R9: Status nibble k (`status_o[4k+3:4k]`) reads {0, stop, 0, hs_active} for data lane k. The clock-lane nibble (index NUM_LANES) carries `mbias_ready_i` in bit 3.
- R10: While `force_stop_i` is high, every data lane drives LP-11 and no new burst starts.
- R11: A data-lane soft reset forces that lane to LP-11 at once. A clock-lane soft reset (`lane_rst_i[NUM_LANES]`) or `phy_rst_i` returns the sequencer to idle on the next clock edge.
- R12: After reset, every powered lane drives LP-11 with high-speed enable low, and `hs_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Lane byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| burst_req_i | input | 1 | Level request for a high-speed burst |
| clk_tim_i | input | 32 | {clk prepare, clk zero, clk post, clk trail} counts |
| hs_tim_i | input | 32 | {hs prepare, hs zero, hs trail, hs exit} counts |
| clk_pre_i | input | 8 | Clock-pre count |
| lpx_i | input | 8 | LPX count |
| lane_cnt_i | input | 3 | Number of active data lanes |
| phy_off_i | input | 1 | Power down the whole PHY |
| phy_rst_i | input | 1 | PHY soft reset |
| lane_rst_i | input | NUM_LANES+1 | Per-lane soft reset, top bit is the clock lane |
| force_stop_i | input | 1 | Hold the data lanes in stop |
| ovr_hs_sel_i | input | NUM_LANES+1 | Per-lane high-speed enable override select |
| ovr_hs_val_i | input | NUM_LANES+1 | Per-lane high-speed enable override value |
| ovr_lp_sel_i | input | NUM_LANES+1 | Per-lane low-power enable override select |
| ovr_lp_val_i | input | NUM_LANES+1 | Per-lane low-power enable override value |
| mbias_ready_i | input | 1 | Analog bias ready, reported in clock status |
| tx_hs_en_o | output | NUM_LANES+1 | High-speed driver enable per lane |
| tx_lp_en_o | output | NUM_LANES+1 | Low-power driver enable per lane |
| lp_dp_o | output | NUM_LANES+1 | Low-power P line level per lane |
| lp_dn_o | output | NUM_LANES+1 | Low-power N line level per lane |
| pd_o | output | NUM_LANES+1 | Lane power-down, top bit is the clock lane and the whole PHY |
| hs_ready_o | output | 1 | Data lanes are ready to carry payload |
| status_o | output | 4*NUM_LANES+4 | Per-lane status nibbles |

## Verification
Ten timing sets are swept arithmetically over every window field. They include zero fields and burst lengths from one to four cycles. For each set the bench measures every line-state run on the clock lane and on the data lanes, and the gaps between them. This tells apart an error in a single field from a swapped field, and an ordering error from a length error. Separate patterns sweep all override select and value combinations on every lane, every lane count with and without PHY power-down, and force-stop and soft resets applied both at idle and in the middle of a burst.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;
  localparam int FLD_W = 8;

  typedef enum logic [1:0] {
    PH_STOP = 2'd0,
    PH_LP01 = 2'd1,
    PH_LP00 = 2'd2,
    PH_HS   = 2'd3
  } lane_ph_e;

  // order matters: timed states advance by +1
  typedef enum logic [3:0] {
    S_IDLE, S_CLK_LP01, S_CLK_LP00, S_CLK_PREP, S_CLK_ZERO, S_CLK_PRE,
    S_DAT_LP01, S_DAT_LP00, S_DAT_PREP, S_DAT_ZERO, S_BURST,
    S_DAT_TRAIL, S_CLK_POST, S_CLK_TRAIL, S_EXIT
  } seq_st_e;
endpackage

// File: rtl/dphy_burst_fsm.sv
module dphy_burst_fsm import dphy_seq_pkg::*; #(
  parameter int CNT_W = FLD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             start_i,
  input  logic             req_i,
  input  logic [CNT_W-1:0] t_lpx_i,
  input  logic [CNT_W-1:0] t_cprep_i,
  input  logic [CNT_W-1:0] t_czero_i,
  input  logic [CNT_W-1:0] t_cpre_i,
  input  logic [CNT_W-1:0] t_hprep_i,
  input  logic [CNT_W-1:0] t_hzero_i,
  input  logic [CNT_W-1:0] t_htrail_i,
  input  logic [CNT_W-1:0] t_cpost_i,
  input  logic [CNT_W-1:0] t_ctrail_i,
  input  logic [CNT_W-1:0] t_hexit_i,
  output lane_ph_e         clk_ph_o,
  output lane_ph_e         dat_ph_o,
  output logic             hs_ready_o
);
  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, dur;
  logic             last;

  assign last = (cnt_q == CNT_W'(1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (start_i) st_d = S_CLK_LP01;
      S_BURST: if (!req_i) st_d = S_DAT_TRAIL;
      S_EXIT:  if (last) st_d = S_IDLE;
      default: if (last) st_d = seq_st_e'(st_q + 4'd1);
    endcase
    if (hold_i) st_d = S_IDLE;
  end

  always_comb begin
    unique case (st_d)
      S_CLK_LP01, S_CLK_LP00,
      S_DAT_LP01, S_DAT_LP00: dur = t_lpx_i;
      S_CLK_PREP:             dur = t_cprep_i;
      S_CLK_ZERO:             dur = t_czero_i;
      S_CLK_PRE:              dur = t_cpre_i;
      S_DAT_PREP:             dur = t_hprep_i;
      S_DAT_ZERO:             dur = t_hzero_i;
      S_DAT_TRAIL:            dur = t_htrail_i;
      S_CLK_POST:             dur = t_cpost_i;
      S_CLK_TRAIL:            dur = t_ctrail_i;
      S_EXIT:                 dur = t_hexit_i;
      default:                dur = '0;
    endcase
    if (st_d != st_q)         cnt_d = (dur == '0) ? CNT_W'(1) : dur;
    else if (cnt_q != '0)     cnt_d = cnt_q - CNT_W'(1);
    else                      cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    unique case (st_q)
      S_IDLE, S_EXIT: clk_ph_o = PH_STOP;
      S_CLK_LP01:     clk_ph_o = PH_LP01;
      S_CLK_LP00:     clk_ph_o = PH_LP00;
      default:        clk_ph_o = PH_HS;
    endcase
    unique case (st_q)
      S_DAT_LP01:                      dat_ph_o = PH_LP01;
      S_DAT_LP00:                      dat_ph_o = PH_LP00;
      S_DAT_PREP, S_DAT_ZERO,
      S_BURST, S_DAT_TRAIL:            dat_ph_o = PH_HS;
      default:                         dat_ph_o = PH_STOP;
    endcase
  end

  assign hs_ready_o = (st_q == S_BURST);
endmodule

// File: rtl/dphy_lane_drv.sv
module dphy_lane_drv import dphy_seq_pkg::*; (
  input  lane_ph_e    ph_i,
  input  logic        stop_i,
  input  logic        pd_i,
  input  logic        hs_sel_i,
  input  logic        hs_val_i,
  input  logic        lp_sel_i,
  input  logic        lp_val_i,
  input  logic        top_bit_i,
  output logic        hs_en_o,
  output logic        lp_en_o,
  output logic        dp_o,
  output logic        dn_o,
  output logic [3:0]  sts_o
);
  lane_ph_e ph;
  logic     hs, lp;

  assign ph = stop_i ? PH_STOP : ph_i;

  always_comb begin
    unique case (ph)
      PH_STOP: {hs, lp, dp_o, dn_o} = 4'b0111;
      PH_LP01: {hs, lp, dp_o, dn_o} = 4'b0101;
      PH_LP00: {hs, lp, dp_o, dn_o} = 4'b0100;
      default: {hs, lp, dp_o, dn_o} = 4'b1000;
    endcase
    if (pd_i) {hs, lp, dp_o, dn_o} = 4'b0000;
  end

  assign hs_en_o = hs_sel_i ? hs_val_i : hs;
  assign lp_en_o = lp_sel_i ? lp_val_i : lp;
  assign sts_o   = {top_bit_i, ~pd_i & (ph == PH_STOP), 1'b0, ~pd_i & (ph == PH_HS)};
endmodule

// File: rtl/dphy_burst_seq.sv
module dphy_burst_seq import dphy_seq_pkg::*; #(
  parameter int NUM_LANES = 4,
  localparam int NL = NUM_LANES + 1,
  localparam int LC_W = $clog2(NUM_LANES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              burst_req_i,
  input  logic [31:0]       clk_tim_i,
  input  logic [31:0]       hs_tim_i,
  input  logic [FLD_W-1:0]  clk_pre_i,
  input  logic [FLD_W-1:0]  lpx_i,
  input  logic [LC_W-1:0]   lane_cnt_i,
  input  logic              phy_off_i,
  input  logic              phy_rst_i,
  input  logic [NL-1:0]     lane_rst_i,
  input  logic              force_stop_i,
  input  logic [NL-1:0]     ovr_hs_sel_i,
  input  logic [NL-1:0]     ovr_hs_val_i,
  input  logic [NL-1:0]     ovr_lp_sel_i,
  input  logic [NL-1:0]     ovr_lp_val_i,
  input  logic              mbias_ready_i,
  output logic [NL-1:0]     tx_hs_en_o,
  output logic [NL-1:0]     tx_lp_en_o,
  output logic [NL-1:0]     lp_dp_o,
  output logic [NL-1:0]     lp_dn_o,
  output logic [NL-1:0]     pd_o,
  output logic              hs_ready_o,
  output logic [4*NL-1:0]   status_o
);
  lane_ph_e clk_ph, dat_ph;
  logic     hold;

  assign hold = phy_rst_i | phy_off_i | lane_rst_i[NUM_LANES];

  dphy_burst_fsm #(.CNT_W(FLD_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (hold),
    .start_i    (burst_req_i & ~force_stop_i),
    .req_i      (burst_req_i),
    .t_lpx_i    (lpx_i),
    .t_cprep_i  (clk_tim_i[31:24]),
    .t_czero_i  (clk_tim_i[23:16]),
    .t_cpre_i   (clk_pre_i),
    .t_hprep_i  (hs_tim_i[31:24]),
    .t_hzero_i  (hs_tim_i[23:16]),
    .t_htrail_i (hs_tim_i[15:8]),
    .t_cpost_i  (clk_tim_i[15:8]),
    .t_ctrail_i (clk_tim_i[7:0]),
    .t_hexit_i  (hs_tim_i[7:0]),
    .clk_ph_o   (clk_ph),
    .dat_ph_o   (dat_ph),
    .hs_ready_o (hs_ready_o)
  );

  for (genvar k = 0; k < NL; k++) begin : g_lane
    logic     stop, top;
    lane_ph_e ph;
    if (k == NUM_LANES) begin : g_clk
      assign ph       = clk_ph;
      assign stop     = lane_rst_i[k] | phy_rst_i;
      assign top      = mbias_ready_i;
      assign pd_o[k]  = phy_off_i;
    end else begin : g_dat
      assign ph       = dat_ph;
      assign stop     = lane_rst_i[k] | phy_rst_i | force_stop_i;
      assign top      = 1'b0;
      assign pd_o[k]  = phy_off_i | (lane_cnt_i <= LC_W'(k));
    end
    dphy_lane_drv u_drv (
      .ph_i      (ph),
      .stop_i    (stop),
      .pd_i      (pd_o[k]),
      .hs_sel_i  (ovr_hs_sel_i[k]),
      .hs_val_i  (ovr_hs_val_i[k]),
      .lp_sel_i  (ovr_lp_sel_i[k]),
      .lp_val_i  (ovr_lp_val_i[k]),
      .top_bit_i (top),
      .hs_en_o   (tx_hs_en_o[k]),
      .lp_en_o   (tx_lp_en_o[k]),
      .dp_o      (lp_dp_o[k]),
      .dn_o      (lp_dn_o[k]),
      .sts_o     (status_o[4*k +: 4])
    );
  end
endmodule

// File: rtl/dphy_burst_seq_chk.sv
module dphy_burst_seq_chk import dphy_seq_pkg::*; #(
  parameter int NUM_LANES = 4,
  localparam int NL = NUM_LANES + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input lane_ph_e      clk_ph,
  input lane_ph_e      dat_ph,
  input logic          hs_ready_o,
  input logic [NL-1:0] pd_o,
  input logic          force_stop_i,
  input logic [NL-1:0] tx_hs_en_o,
  input logic [NL-1:0] ovr_hs_sel_i,
  input logic          phy_rst_i,
  input logic          phy_off_i,
  input logic [NL-1:0] lane_rst_i
);
  AST_CLK_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_ph == PH_STOP) |=> (clk_ph == PH_STOP || clk_ph == PH_LP01)); // R1
  AST_DAT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_ph == PH_STOP) |=> (dat_ph == PH_STOP || dat_ph == PH_LP01)); // R1
  AST_CLK_LEADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_ph != PH_STOP) |-> (clk_ph == PH_HS)); // R2
  AST_READY_IN_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_ready_o |-> (clk_ph == PH_HS && dat_ph == PH_HS)); // R3
  AST_FORCE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_stop_i |-> ((tx_hs_en_o[NUM_LANES-1:0] & ~ovr_hs_sel_i[NUM_LANES-1:0]) == '0)); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_rst_i || phy_off_i || lane_rst_i[NUM_LANES]) |=> (clk_ph == PH_STOP && !hs_ready_o)); // R11
  for (genvar i = 0; i + 1 < NUM_LANES; i++) begin : g_thermo
    AST_PD_THERMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pd_o[i] |-> pd_o[i+1]); // R6
  end
endmodule

bind dphy_burst_seq dphy_burst_seq_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clk_ph       (clk_ph),
  .dat_ph       (dat_ph),
  .hs_ready_o   (hs_ready_o),
  .pd_o         (pd_o),
  .force_stop_i (force_stop_i),
  .tx_hs_en_o   (tx_hs_en_o),
  .ovr_hs_sel_i (ovr_hs_sel_i),
  .phy_rst_i    (phy_rst_i),
  .phy_off_i    (phy_off_i),
  .lane_rst_i   (lane_rst_i)
);

// File: tb/dphy_burst_seq_test.sv
module dphy_burst_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int NL = N + 1;

  logic clk = 0, rst_n = 0;
  logic burst_req = 0;
  logic [31:0] clk_tim = '0, hs_tim = '0;
  logic [7:0]  clk_pre = '0, lpx = '0;
  logic [2:0]  lane_cnt = 3'd4;
  logic phy_off = 0, phy_rst = 0, force_stop = 0, mbias = 1;
  logic [NL-1:0] lane_rst = '0, hs_sel = '0, hs_val = '0, lp_sel = '0, lp_val = '0;
  logic [NL-1:0] hs_en, lp_en, dp, dn, pd;
  logic hs_ready;
  logic [4*NL-1:0] status;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int cph [0:1023];
  int dph [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  dphy_burst_seq #(.NUM_LANES(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .burst_req_i(burst_req),
    .clk_tim_i(clk_tim), .hs_tim_i(hs_tim), .clk_pre_i(clk_pre), .lpx_i(lpx),
    .lane_cnt_i(lane_cnt), .phy_off_i(phy_off), .phy_rst_i(phy_rst),
    .lane_rst_i(lane_rst), .force_stop_i(force_stop),
    .ovr_hs_sel_i(hs_sel), .ovr_hs_val_i(hs_val),
    .ovr_lp_sel_i(lp_sel), .ovr_lp_val_i(lp_val), .mbias_ready_i(mbias),
    .tx_hs_en_o(hs_en), .tx_lp_en_o(lp_en), .lp_dp_o(dp), .lp_dn_o(dn),
    .pd_o(pd), .hs_ready_o(hs_ready), .status_o(status)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0 stop, 1 LP-01, 2 LP-00, 3 HS, 4 off, 5 other
  function automatic int ph(input int k);
    if (hs_en[k] && !lp_en[k]) return 3;
    if (!lp_en[k]) return 4;
    if (dp[k] && dn[k]) return 0;
    if (!dp[k] && dn[k]) return 1;
    if (!dp[k] && !dn[k]) return 2;
    return 5;
  endfunction

  function automatic int d1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int run_len(input bit clk_side, input int s);
    int n = 0;
    int v = clk_side ? cph[s] : dph[s];
    while (s + n < 1024 && (clk_side ? cph[s+n] : dph[s+n]) == v) n++;
    return n;
  endfunction

  function automatic int first_of(input bit clk_side, input int v);
    for (int i = 0; i < 1024; i++) if ((clk_side ? cph[i] : dph[i]) == v) return i;
    return -1;
  endfunction

  task automatic sweep_burst(input int c);
    int lx, cp, cz, cpr, hp, hz, ht, cpo, ctr, hx, w;
    int n, rdy_cnt, a, l1, l2, h0, lh, ls, b, e1, e2, dh;
    bit dropped, lanes_ok;
    lx = c % 3; cp = (c + 1) % 4; cz = (c * 3) % 5; cpr = (c * 2) % 3;
    hp = c % 2; hz = (c + 2) % 4; ht = (c * 5) % 3; cpo = (c + 1) % 3;
    ctr = c % 4; hx = (c * 7) % 5; w = 1 + c % 4;
    clk_tim = {8'(cp), 8'(cz), 8'(cpo), 8'(ctr)};
    hs_tim  = {8'(hp), 8'(hz), 8'(ht), 8'(hx)};
    clk_pre = 8'(cpr); lpx = 8'(lx);
    for (int i = 0; i < 1024; i++) begin cph[i] = -1; dph[i] = -1; end
    n = 0; rdy_cnt = 0; dropped = 0; lanes_ok = 1;
    burst_req = 1;
    while (n < 1024) begin
      @(negedge clk);
      cph[n] = ph(N); dph[n] = ph(0);
      for (int k = 1; k < N; k++) if (ph(k) != dph[n]) lanes_ok = 0;
      if (hs_ready) rdy_cnt++;
      if (dropped) burst_req = 1;
      else if (rdy_cnt == w) begin burst_req = 0; dropped = 1; end
      n++;
      if (dropped && cph[n-1] == 1 && n > 2 && cph[n-2] == 0) break;
    end
    a  = first_of(1'b1, 1);
    l1 = run_len(1'b1, a);
    l2 = run_len(1'b1, a + l1);
    h0 = a + l1 + l2;
    lh = run_len(1'b1, h0);
    ls = run_len(1'b1, h0 + lh);
    b  = first_of(1'b0, 1);
    e1 = run_len(1'b0, b);
    e2 = run_len(1'b0, b + e1);
    dh = run_len(1'b0, b + e1 + e2);
    chk("R1 R5 clock LP-01 length", l1, d1(lx));
    chk("R1 R5 clock LP-00 state", cph[a + l1], 2);
    chk("R1 R5 clock LP-00 length", l2, d1(lx));
    chk("R1 clock HS after LP-00", cph[h0], 3);
    chk("R2 R5 data entry offset", b - h0, d1(cp) + d1(cz) + d1(cpr));
    chk("R1 R5 data LP-01 length", e1, d1(lx));
    chk("R1 R5 data LP-00 length", e2, d1(lx));
    chk("R3 R5 data HS length", dh, d1(hp) + d1(hz) + w + d1(ht));
    chk("R3 ready cycles", rdy_cnt, w);
    chk("R3 data lanes agree", int'(lanes_ok), 1);
    chk("R4 R5 clock tail", (h0 + lh) - (b + e1 + e2 + dh), d1(cpo) + d1(ctr));
    chk("R4 clock returns to stop", cph[h0 + lh], 0);
    chk("R4 R5 exit gap", ls, d1(hx) + 1);
    burst_req = 0;
    repeat (250) @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 400 && !hs_ready; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    for (int k = 0; k < NL; k++) chk("R12 lane stop after reset", ph(k), 0);
    chk("R12 ready low after reset", int'(hs_ready), 0);
    chk("R12 no power-down", int'(pd), 0);
    chk("R9 idle status word", int'(status), 32'hC4444);
    mbias = 0; #1;
    chk("R9 clock nibble follows bias ready", int'(status[4*N +: 4]), 4);
    mbias = 1;

    for (int c = 0; c < 10; c++) sweep_burst(c);

    // R6 R7 power-down sweep
    for (int off = 0; off < 2; off++)
      for (int cnt = 0; cnt <= N; cnt++) begin
        int exp_pd;
        phy_off = off[0]; lane_cnt = 3'(cnt);
        @(negedge clk);
        exp_pd = off ? 31 : 0;
        for (int k = 0; k < N; k++) if (k >= cnt) exp_pd |= (1 << k);
        chk("R6 power-down pattern", int'(pd), exp_pd);
        for (int k = 0; k < NL; k++)
          if (exp_pd[k]) chk("R7 powered-down lane outputs", int'({hs_en[k], lp_en[k], dp[k], dn[k]}), 0);
      end
    phy_off = 0; lane_cnt = 3'd4;
    repeat (2) @(negedge clk);

    // R8 override sweep at idle
    for (int k = 0; k < NL; k++)
      for (int m = 0; m < 16; m++) begin
        hs_sel = '0; hs_val = '0; lp_sel = '0; lp_val = '0;
        hs_sel[k] = m[0]; hs_val[k] = m[1]; lp_sel[k] = m[2]; lp_val[k] = m[3];
        #1;
        chk("R8 hs enable override", int'(hs_en[k]), m[0] ? int'(m[1]) : 0);
        chk("R8 lp enable override", int'(lp_en[k]), m[2] ? int'(m[3]) : 1);
      end
    hs_sel = '0; hs_val = '0; lp_sel = '0; lp_val = '0;
    @(negedge clk);

    // R10 force stop blocks start
    force_stop = 1; burst_req = 1;
    begin
      int moved = 0;
      repeat (30) begin @(negedge clk); if (ph(N) != 0 || ph(0) != 0) moved++; end
      chk("R10 no burst under force stop", moved, 0);
    end
    force_stop = 0;
    wait_ready();
    chk("R3 burst reached ready", int'(hs_ready), 1);
    chk("R9 data status in burst", int'(status[3:0]), 1);
    chk("R9 clock status in burst", int'(status[4*N +: 4]), 9);
    force_stop = 1; #1;
    for (int k = 0; k < N; k++) chk("R10 data lane forced to stop", ph(k), 0);
    chk("R10 clock lane unaffected", ph(N), 3);
    force_stop = 0; #1;
    lane_rst[2] = 1; #1;
    chk("R11 reset data lane stops", ph(2), 0);
    chk("R11 other data lane stays HS", ph(0), 3);
    lane_rst[2] = 0;
    lane_rst[N] = 1;
    @(negedge clk);
    chk("R11 clock reset idles clock", ph(N), 0);
    chk("R11 clock reset idles data", ph(0), 0);
    chk("R11 clock reset drops ready", int'(hs_ready), 0);
    lane_rst[N] = 0;
    wait_ready();
    phy_rst = 1;
    @(negedge clk);
    chk("R11 phy reset drops ready", int'(hs_ready), 0);
    chk("R11 phy reset idles clock", ph(N), 0);
    phy_rst = 0; burst_req = 0;
    repeat (5) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule